// File: doc/BRIEF.md
# Path Metric Purge Threshold Unit

This block decides, for each of the 64 states of a Viterbi decoder running the T-algorithm, whether that state stays alive in the current trellis step. Searching for the true minimum of the freshly computed path metrics would sit in the add-compare-select feedback loop. The block avoids that search. It estimates the best metric from the previous step's path metrics and from the smallest branch metric of each branch metric group, so the estimate is ready while the new metrics are still being formed.

The metrics are split into four groups of sixteen states. Each group is reduced by two levels of four-input minimum comparators. Each group minimum is added, with saturation, to that group's smallest branch metric. A final four-input comparator picks the smallest of the four sums. A programmable margin is added to that estimate, again with saturation, to give the purge threshold. Every new path metric is compared against the threshold. The threshold and one keep flag per state are registered, so both appear one clock after the metrics that produced them.

Top module: `pm_purge_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every keep flag reads 1 and the threshold output reads 255.
- R2: The estimate is the smallest, over groups g = 0..3, of sat(min of previous metrics of states 16g..16g+15 + branch minimum g). The threshold is sat(estimate + margin).
- R3: All additions saturate at 255. The threshold is never below the estimate and never below the margin.
- R4: Keep flag s is 1 when new metric s is less than or equal to the threshold, and 0 when it is greater.
- R5: The threshold and the flags for a set of inputs appear at the outputs on the clock edge that samples those inputs, so they are valid one cycle later.
- R6: Any state whose new metric is less than or equal to the estimate is always kept, for every margin value.
- R7: With a margin of 0, the threshold equals the estimate exactly.
- R8: The metric of state s occupies bits [8s+7:8s] of each metric bus. Branch minimum g occupies bits [8g+7:8g]. Keep flag s is bit s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_prev_i | input | 512 | Path metrics of the previous trellis step, 8 bits per state |
| bm_min_i | input | 32 | Smallest branch metric of each of the four groups, 8 bits per group |
| pm_new_i | input | 512 | Path metrics of the current step, 8 bits per state |
| margin_i | input | 6 | Programmable margin T added to the estimate |
| keep_o | output | 64 | One flag per state: 1 keeps the state, 0 purges it |
| thr_o | output | 8 | Registered purge threshold |

## Verification
Both results are due one clock after their inputs. The threshold and the flags share a single register stage. The bench changes inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. At that point the outputs reflect exactly the vector just applied. Expected values are recomputed for that vector by bench functions that scan all 64 states directly, without using the comparator tree.

// File: rtl/pm_purge_pkg.sv
package pm_purge_pkg;
  parameter int PM_W = 8;
  localparam logic [PM_W-1:0] PM_MAX = {PM_W{1'b1}};

  function automatic logic [PM_W-1:0] sat_add(input logic [PM_W-1:0] a,
                                               input logic [PM_W-1:0] b);
    logic [PM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PM_W] ? PM_MAX : s[PM_W-1:0];
  endfunction

  function automatic logic [PM_W-1:0] min2(input logic [PM_W-1:0] a,
                                           input logic [PM_W-1:0] b);
    return (a <= b) ? a : b;
  endfunction
endpackage

// File: rtl/pm_min4.sv
module pm_min4 #(
  parameter int W = 8
) (
  input  logic [4*W-1:0] vals_i,
  output logic [W-1:0]   min_o
);
  logic [W-1:0] lo_pair;
  logic [W-1:0] hi_pair;

  always_comb begin
    lo_pair = (vals_i[0*W +: W] <= vals_i[1*W +: W]) ? vals_i[0*W +: W] : vals_i[1*W +: W];
    hi_pair = (vals_i[2*W +: W] <= vals_i[3*W +: W]) ? vals_i[2*W +: W] : vals_i[3*W +: W];
    min_o   = (lo_pair <= hi_pair) ? lo_pair : hi_pair;
  end
endmodule

// File: rtl/pm_group_min.sv
module pm_group_min #(
  parameter int W = 8
) (
  input  logic [16*W-1:0] vals_i,
  output logic [W-1:0]    min_o
);
  logic [4*W-1:0] stage1;

  for (genvar q = 0; q < 4; q++) begin : g_quad
    pm_min4 #(.W(W)) u_quad (
      .vals_i(vals_i[q*4*W +: 4*W]),
      .min_o (stage1[q*W +: W])
    );
  end

  pm_min4 #(.W(W)) u_final (
    .vals_i(stage1),
    .min_o (min_o)
  );
endmodule

// File: rtl/pm_purge_top.sv
module pm_purge_top
  import pm_purge_pkg::*;
#(
  parameter int NUM_STATES = 64,
  parameter int GROUP_SIZE = 16,
  parameter int T_W        = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_STATES*PM_W-1:0] pm_prev_i,
  input  logic [4*PM_W-1:0]          bm_min_i,
  input  logic [NUM_STATES*PM_W-1:0] pm_new_i,
  input  logic [T_W-1:0]             margin_i,
  output logic [NUM_STATES-1:0]      keep_o,
  output logic [PM_W-1:0]            thr_o
);
  localparam int NUM_GROUPS = NUM_STATES / GROUP_SIZE;

  // The comparator tree is built for four groups of sixteen states.
  initial begin
    if (NUM_GROUPS != 4 || GROUP_SIZE != 16)
      $error("pm_purge_top: tree needs 4 groups of 16 states");
  end

  logic [NUM_GROUPS*PM_W-1:0] grp_min_w;
  logic [NUM_GROUPS*PM_W-1:0] grp_est_w;
  logic [PM_W-1:0]            est_w;
  logic [PM_W-1:0]            thr_w;
  logic [NUM_STATES-1:0]      keep_w;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pm_group_min #(.W(PM_W)) u_gmin (
      .vals_i(pm_prev_i[g*GROUP_SIZE*PM_W +: GROUP_SIZE*PM_W]),
      .min_o (grp_min_w[g*PM_W +: PM_W])
    );
    assign grp_est_w[g*PM_W +: PM_W] =
      sat_add(grp_min_w[g*PM_W +: PM_W], bm_min_i[g*PM_W +: PM_W]);
  end

  pm_min4 #(.W(PM_W)) u_est (
    .vals_i(grp_est_w),
    .min_o (est_w)
  );

  assign thr_w = sat_add(est_w, PM_W'(margin_i));

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_cmp
    assign keep_w[s] = (pm_new_i[s*PM_W +: PM_W] <= thr_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_o <= '1;
      thr_o  <= PM_MAX;
    end else begin
      keep_o <= keep_w;
      thr_o  <= thr_w;
    end
  end
endmodule

// File: rtl/pm_purge_chk.sv
module pm_purge_chk
  import pm_purge_pkg::*;
#(
  parameter int NUM_STATES = 64,
  parameter int T_W        = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_STATES*PM_W-1:0] pm_new_i,
  input logic [T_W-1:0]             margin_i,
  input logic [PM_W-1:0]            est_w,
  input logic [NUM_STATES-1:0]      keep_o,
  input logic [PM_W-1:0]            thr_o
);
  assert_thr_ge_margin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_o >= PM_W'($past(margin_i)));

  assert_thr_ge_est_R3: assert property (@(posedge clk) disable iff (!rst_n)
    thr_o >= $past(est_w));

  assert_zero_margin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(margin_i) == '0 |-> thr_o == $past(est_w));

  assert_max_thr_keeps_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_o == PM_MAX |-> &keep_o);

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_best
    assert_best_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pm_new_i[s*PM_W +: PM_W] <= est_w) |-> keep_o[s]);
  end
endmodule

bind pm_purge_top pm_purge_chk #(.NUM_STATES(NUM_STATES), .T_W(T_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pm_new_i(pm_new_i),
  .margin_i(margin_i),
  .est_w   (est_w),
  .keep_o  (keep_o),
  .thr_o   (thr_o)
);

// File: tb/test_pm_purge_top.sv
`timescale 1ns/1ps
module test_pm_purge_top;
  localparam int NS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS*8-1:0] pm_prev, pm_new;
  logic [31:0]   bm_min;
  logic [5:0]    margin;
  logic [NS-1:0] keep;
  logic [7:0]    thr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  pm_purge_top i_pm_purge_top (
    .clk(clk), .rst_n(rst_n), .pm_prev_i(pm_prev), .bm_min_i(bm_min),
    .pm_new_i(pm_new), .margin_i(margin), .keep_o(keep), .thr_o(thr)
  );

  function automatic int ref_est(input logic [NS*8-1:0] prev, input logic [31:0] bm);
    int best = 1000;
    for (int g = 0; g < 4; g++) begin
      int m = 1000;
      for (int s = 16*g; s < 16*g+16; s++)
        if (int'(prev[s*8 +: 8]) < m) m = int'(prev[s*8 +: 8]);
      m = m + int'(bm[g*8 +: 8]);
      if (m > 255) m = 255;
      if (m < best) best = m;
    end
    return best;
  endfunction

  function automatic int ref_thr(input int est, input int t);
    return (est + t > 255) ? 255 : est + t;
  endfunction

  task automatic check_out(input string req, input logic [NS-1:0] exp_keep, input int exp_thr);
    n_tests++;
    if (thr !== 8'(exp_thr) || keep !== exp_keep) begin
      n_fail++;
      $display("FAIL %s: thr=%0d keep=%h expected thr=%0d keep=%h", req, thr, keep, exp_thr, exp_keep);
    end
  endtask

  task automatic apply_check(input string req);
    int e, t;
    logic [NS-1:0] k;
    e = ref_est(pm_prev, bm_min);
    t = ref_thr(e, int'(margin));
    for (int s = 0; s < NS; s++) k[s] = (int'(pm_new[s*8 +: 8]) <= t);
    @(posedge clk);
    @(negedge clk);
    check_out(req, k, t);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    pm_prev = '0; pm_new = '1; bm_min = '0; margin = 6'd3;
    repeat (3) @(negedge clk);
    check_out("R1 reset", '1, 255);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 / R2: single minimum in group 2 at state 37, offset by its branch minimum
    pm_prev = {NS{8'd200}};
    pm_prev[37*8 +: 8] = 8'd10;
    bm_min = {8'd1, 8'd5, 8'd2, 8'd1};
    pm_new = {NS{8'd100}};
    pm_new[5*8 +: 8] = 8'd17;
    pm_new[9*8 +: 8] = 8'd18;
    margin = 6'd5;
    apply_check("R2 R8 group estimate");

    // R7 / R6: zero margin, one new metric equal to the estimate
    margin = 6'd0;
    pm_new[5*8 +: 8] = 8'd15;
    pm_new[6*8 +: 8] = 8'd16;
    apply_check("R7 R6 zero margin");

    // R3: saturation of both additions
    pm_prev = {NS{8'd250}};
    bm_min = {4{8'd20}};
    margin = 6'd63;
    pm_new = {NS{8'd255}};
    apply_check("R3 saturation");

    // R3: estimate zero, threshold equals margin
    pm_prev = {NS{8'd0}};
    bm_min = '0;
    margin = 6'd63;
    for (int s = 0; s < NS; s++) pm_new[s*8 +: 8] = 8'(s + 30);
    apply_check("R3 R4 margin only");

    // R4: all metrics equal
    pm_prev = {NS{8'd40}};
    bm_min = {4{8'd4}};
    margin = 6'd1;
    pm_new = {NS{8'd45}};
    apply_check("R4 all equal just above");

    // R5: back-to-back vectors, each due exactly one cycle later
    for (int i = 0; i < 200; i++) begin
      for (int s = 0; s < NS; s++) begin
        pm_prev[s*8 +: 8] = 8'($urandom_range(0, 255));
        pm_new[s*8 +: 8]  = 8'($urandom_range(0, 255));
      end
      for (int g = 0; g < 4; g++) bm_min[g*8 +: 8] = 8'($urandom_range(0, 40));
      margin = 6'($urandom_range(0, 63));
      apply_check("R2 R4 R5 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule